// File: doc/BRIEF.md
# Long-Mode Effective Address Generator

This block forms the 64-bit virtual address of a memory operand for a processor that runs either in a full 64-bit sub-mode or in a compatibility sub-mode for older 16-bit and 32-bit code. Each request supplies a base register value, an index register value with a scale code, a displacement with a size code, and a segment identifier with that segment's base address. The block adds base, scaled index and sign-extended displacement. It cuts the sum down to the active address size and zero-fills the upper bits. It then applies the segment base that the sub-mode allows.

The active address size depends on the sub-mode flag and the override flag. In 64-bit mode the override narrows addressing to 32 bits. In compatibility mode the default is 32 bits and the override selects 16 bits. In 64-bit mode only two of the segments (the ones coded 4 and 5) contribute a base; all the others count as zero. In compatibility mode the selected base is added inside a 32-bit space.

The result is registered with one cycle of latency. A valid flag follows the request strobe. Limit checks, paging, faults and decode are handled elsewhere.

Top module: `lm_addr_gen`

## Requirements
- R1: With mode64=1 and asz_ovr=0, the address is base + scaled index + extended displacement, taken modulo 2^64, with no truncation.
- R2: disp_sz code 0, 1 and 2 take the low 8, 16 and 32 bits of disp_val respectively and sign-extend them to 64 bits. Higher bits of disp_val are ignored.
- R3: disp_sz code 3 uses all 64 bits of disp_val when mode64=1. When mode64=0, code 3 behaves exactly as code 2.
- R4: scale code s (0..3) multiplies the index by 2^s. When base_en=0 the base contributes zero, and when idx_en=0 the index contributes zero, whatever their values.
- R5: With mode64=1 and asz_ovr=1, the sum is truncated to its low 32 bits and zero-extended before any segment base is applied.
- R6: With mode64=0, the address size is 32 bits when asz_ovr=0 and 16 bits when asz_ovr=1. The sum is truncated to that size and zero-extended.
- R7: With mode64=1, seg_id codes 0, 1, 2, 3, 6 and 7 contribute no base. Codes 4 and 5 add the full 64-bit seg_base to the truncated sum, modulo 2^64.
- R8: With mode64=0, the low 32 bits of seg_base are added to the truncated sum for every seg_id. The result wraps within 32 bits, and bits 63:32 of the output are zero.
- R9: A request with in_vld high at one rising edge shows on out_vld and out_addr right after that edge. After an edge with in_vld low, out_vld is low and out_addr keeps its value.
- R10: A synchronous reset (rst high at a rising edge) clears out_vld and out_addr to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Request strobe |
| mode64 | input | 1 | 1 = 64-bit sub-mode, 0 = compatibility sub-mode |
| asz_ovr | input | 1 | Address-size override |
| base_val | input | 64 | Base register value |
| base_en | input | 1 | Base register in use |
| idx_val | input | 64 | Index register value |
| idx_en | input | 1 | Index register in use |
| scale | input | 2 | Index scale code (x1, x2, x4, x8) |
| disp_val | input | 64 | Displacement, meaningful bits set by disp_sz |
| disp_sz | input | 2 | Displacement size code |
| seg_id | input | 3 | Segment identifier |
| seg_base | input | 64 | Base address of the selected segment |
| out_vld | output | 1 | Address valid |
| out_addr | output | 64 | Virtual address |

## Verification
Displacements are given negative values, and the upper bits of disp_val are filled with noise. A design that zero-extends, or that reads bits beyond the size code, produces addresses that are off by a large amount. Sums are chosen so they cross the 4 GB and 64 KB lines under the 32-bit and 16-bit sizes. A design that truncates before adding, or after adding the segment base, leaves a stray carry in bit 32 or bit 16. Every segment code is tried in both sub-modes with a non-zero base, so a design that lets the data-segment base through in 64-bit mode, or that drops it in compatibility mode, returns a shifted address. Further cases use a segment base that wraps the 32-bit space, the wide displacement in compatibility mode, cleared enables, and idle cycles between requests; these catch a wrong wrap, a leak of the wide form, and an output that fails to hold.

// File: rtl/lmag_pkg.sv
package lmag_pkg;

   typedef enum logic [1:0] {
      DSZ_8    = 2'd0,
      DSZ_16   = 2'd1,
      DSZ_32   = 2'd2,
      DSZ_WIDE = 2'd3
   } dsz_e;

   typedef enum logic [1:0] {
      ASZ_16   = 2'd0,
      ASZ_32   = 2'd1,
      ASZ_FULL = 2'd2
   } asz_e;

   typedef enum logic [2:0] {
      SEG_ES = 3'd0,
      SEG_CS = 3'd1,
      SEG_SS = 3'd2,
      SEG_DS = 3'd3,
      SEG_FS = 3'd4,
      SEG_GS = 3'd5
   } seg_e;

   localparam int BYTE_W = 8;

   // segments whose base survives in the 64-bit sub-mode
   function automatic logic seg_keeps_base(input logic [2:0] id);
      return (id == 3'(SEG_FS)) || (id == 3'(SEG_GS));
   endfunction

   // address size chosen by sub-mode and override
   function automatic asz_e pick_asz(input logic m64, input logic ovr);
      if (m64) return ovr ? ASZ_32 : ASZ_FULL;
      else     return ovr ? ASZ_16 : ASZ_32;
   endfunction

endpackage

// File: rtl/lmag_disp_ext.sv
module lmag_disp_ext
   import lmag_pkg::*;
#(
   parameter int ADDR_W   = 64,
   parameter int NARROW_W = 32,
   parameter int SHORT_W  = 16
) (
   input  logic [ADDR_W-1:0] disp_raw,
   input  logic [1:0]        disp_sz,
   input  logic              mode64,
   output logic [ADDR_W-1:0] disp_ext
);
   localparam int PAD_B = ADDR_W - BYTE_W;
   localparam int PAD_S = ADDR_W - SHORT_W;
   localparam int PAD_N = ADDR_W - NARROW_W;

   logic [ADDR_W-1:0] ext_b;
   logic [ADDR_W-1:0] ext_s;
   logic [ADDR_W-1:0] ext_n;

   assign ext_b = {{PAD_B{disp_raw[BYTE_W-1]}},   disp_raw[BYTE_W-1:0]};
   assign ext_s = {{PAD_S{disp_raw[SHORT_W-1]}},  disp_raw[SHORT_W-1:0]};
   assign ext_n = {{PAD_N{disp_raw[NARROW_W-1]}}, disp_raw[NARROW_W-1:0]};

   always_comb begin
      case (dsz_e'(disp_sz))
         DSZ_8:    disp_ext = ext_b;
         DSZ_16:   disp_ext = ext_s;
         DSZ_32:   disp_ext = ext_n;
         // wide form exists only in the 64-bit sub-mode
         DSZ_WIDE: disp_ext = mode64 ? disp_raw : ext_n;
         default:  disp_ext = ext_n;
      endcase
   end
endmodule

// File: rtl/lmag_ea_sum.sv
module lmag_ea_sum #(
   parameter int ADDR_W     = 64,
   parameter int SCALE_W    = 2,
   parameter int SCALE_IMPL = 0,
   parameter int SUM_IMPL   = 1
) (
   input  logic [ADDR_W-1:0]  base_val,
   input  logic               base_en,
   input  logic [ADDR_W-1:0]  idx_val,
   input  logic               idx_en,
   input  logic [SCALE_W-1:0] scale,
   input  logic [ADDR_W-1:0]  disp_ext,
   output logic [ADDR_W-1:0]  ea
);
   localparam int SCALE_N = 1 << SCALE_W;

   logic [ADDR_W-1:0] base_g;
   logic [ADDR_W-1:0] idx_g;
   logic [ADDR_W-1:0] scaled;

   assign base_g = base_en ? base_val : '0;
   assign idx_g  = idx_en  ? idx_val  : '0;

   if (SCALE_IMPL == 0) begin : g_scale_shift
      assign scaled = idx_g << scale;
   end else begin : g_scale_mux
      always_comb begin
         scaled = '0;
         for (int k = 0; k < SCALE_N; k++) begin
            if (scale == SCALE_W'(k)) scaled = idx_g << k;
         end
      end
   end

   if (SUM_IMPL == 0) begin : g_sum_chain
      assign ea = base_g + scaled + disp_ext;
   end else begin : g_sum_csa
      logic [ADDR_W-1:0] csa_s;
      logic [ADDR_W-1:0] csa_c;
      logic [ADDR_W-1:0] csa_c_sh;
      assign csa_s    = base_g ^ scaled ^ disp_ext;
      assign csa_c    = (base_g & scaled) | (base_g & disp_ext) | (scaled & disp_ext);
      assign csa_c_sh = {csa_c[ADDR_W-2:0], 1'b0};
      assign ea       = csa_s + csa_c_sh;
   end
endmodule

// File: rtl/lmag_size_clip.sv
module lmag_size_clip
   import lmag_pkg::*;
#(
   parameter int ADDR_W   = 64,
   parameter int NARROW_W = 32,
   parameter int SHORT_W  = 16
) (
   input  logic [ADDR_W-1:0] ea,
   input  asz_e              asz,
   output logic [ADDR_W-1:0] clip
);
   localparam logic [ADDR_W-1:0] MASK_N = {{(ADDR_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
   localparam logic [ADDR_W-1:0] MASK_S = {{(ADDR_W-SHORT_W){1'b0}},  {SHORT_W{1'b1}}};

   always_comb begin
      case (asz)
         ASZ_FULL: clip = ea;
         ASZ_32:   clip = ea & MASK_N;
         ASZ_16:   clip = ea & MASK_S;
         default:  clip = ea & MASK_N;
      endcase
   end
endmodule

// File: rtl/lmag_seg_apply.sv
module lmag_seg_apply
   import lmag_pkg::*;
#(
   parameter int ADDR_W   = 64,
   parameter int NARROW_W = 32
) (
   input  logic [ADDR_W-1:0] clip,
   input  logic              mode64,
   input  logic [2:0]        seg_id,
   input  logic [ADDR_W-1:0] seg_base,
   output logic [ADDR_W-1:0] va
);
   localparam int PAD_N = ADDR_W - NARROW_W;

   logic [ADDR_W-1:0]   wide_add;
   logic [ADDR_W-1:0]   wide_va;
   logic [NARROW_W-1:0] narrow_sum;
   logic [ADDR_W-1:0]   compat_va;

   assign wide_add   = seg_keeps_base(seg_id) ? seg_base : '0;
   assign wide_va    = clip + wide_add;
   assign narrow_sum = clip[NARROW_W-1:0] + seg_base[NARROW_W-1:0];
   assign compat_va  = {{PAD_N{1'b0}}, narrow_sum};
   assign va         = mode64 ? wide_va : compat_va;
endmodule

// File: rtl/lm_addr_gen.sv
module lm_addr_gen
   import lmag_pkg::*;
#(
   parameter int ADDR_W     = 64,
   parameter int NARROW_W   = 32,
   parameter int SHORT_W    = 16,
   parameter int SCALE_W    = 2,
   parameter int SCALE_IMPL = 0,
   parameter int SUM_IMPL   = 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_vld,
   input  logic              mode64,
   input  logic              asz_ovr,
   input  logic [63:0]       base_val,
   input  logic              base_en,
   input  logic [63:0]       idx_val,
   input  logic              idx_en,
   input  logic [1:0]        scale,
   input  logic [63:0]       disp_val,
   input  logic [1:0]        disp_sz,
   input  logic [2:0]        seg_id,
   input  logic [63:0]       seg_base,
   output logic              out_vld,
   output logic [63:0]       out_addr
);
   // elaboration-time parameter checks
   if (ADDR_W != 64) begin : g_chk_addr
      $error("lm_addr_gen: ADDR_W must match the 64-bit port width");
   end
   if (!(SHORT_W > BYTE_W && NARROW_W > SHORT_W && ADDR_W > NARROW_W)) begin : g_chk_order
      $error("lm_addr_gen: widths must satisfy 8 < SHORT_W < NARROW_W < ADDR_W");
   end
   if (SCALE_W != 2) begin : g_chk_scale
      $error("lm_addr_gen: SCALE_W must match the 2-bit scale port");
   end
   if (SCALE_IMPL < 0 || SCALE_IMPL > 1 || SUM_IMPL < 0 || SUM_IMPL > 1) begin : g_chk_impl
      $error("lm_addr_gen: SCALE_IMPL and SUM_IMPL take 0 or 1");
   end

   asz_e              asz;
   logic [ADDR_W-1:0] disp_ext;
   logic [ADDR_W-1:0] ea;
   logic [ADDR_W-1:0] clip;
   logic [ADDR_W-1:0] va;
   logic              vld_q;
   logic [ADDR_W-1:0] addr_q;

   assign asz = pick_asz(mode64, asz_ovr);

   lmag_disp_ext #(
      .ADDR_W(ADDR_W), .NARROW_W(NARROW_W), .SHORT_W(SHORT_W)
   ) u_disp (
      .disp_raw(disp_val), .disp_sz(disp_sz), .mode64(mode64), .disp_ext(disp_ext)
   );

   lmag_ea_sum #(
      .ADDR_W(ADDR_W), .SCALE_W(SCALE_W), .SCALE_IMPL(SCALE_IMPL), .SUM_IMPL(SUM_IMPL)
   ) u_sum (
      .base_val(base_val), .base_en(base_en), .idx_val(idx_val), .idx_en(idx_en),
      .scale(scale), .disp_ext(disp_ext), .ea(ea)
   );

   lmag_size_clip #(
      .ADDR_W(ADDR_W), .NARROW_W(NARROW_W), .SHORT_W(SHORT_W)
   ) u_clip (
      .ea(ea), .asz(asz), .clip(clip)
   );

   lmag_seg_apply #(
      .ADDR_W(ADDR_W), .NARROW_W(NARROW_W)
   ) u_seg (
      .clip(clip), .mode64(mode64), .seg_id(seg_id), .seg_base(seg_base), .va(va)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         vld_q  <= 1'b0;
         addr_q <= '0;
      end else begin
         vld_q <= in_vld;
         if (in_vld) addr_q <= va;
      end
   end

   assign out_vld  = vld_q;
   assign out_addr = addr_q;
endmodule

// File: rtl/lmag_chk.sv
module lmag_chk (
   input logic        clk,
   input logic        rst,
   input logic        in_vld,
   input logic        mode64,
   input logic        asz_ovr,
   input logic        base_en,
   input logic        idx_en,
   input logic [63:0] disp_val,
   input logic [2:0]  seg_id,
   input logic [63:0] seg_base,
   input logic        out_vld,
   input logic [63:0] out_addr
);
   a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
      in_vld |=> out_vld);

   a_r9_idle_low: assert property (@(posedge clk) disable iff (rst)
      !in_vld |=> !out_vld);

   a_r9_hold: assert property (@(posedge clk) disable iff (rst)
      !in_vld |=> $stable(out_addr));

   a_r10_reset_clear: assert property (@(posedge clk)
      rst |=> (!out_vld && out_addr == 64'd0));

   a_r8_compat_low4g: assert property (@(posedge clk) disable iff (rst)
      (in_vld && !mode64) |=> (out_addr[63:32] == 32'd0));

   a_r5_ovr_low4g: assert property (@(posedge clk) disable iff (rst)
      (in_vld && mode64 && asz_ovr && seg_id != 3'd4 && seg_id != 3'd5)
      |=> (out_addr[63:32] == 32'd0));

   a_r6_short_range: assert property (@(posedge clk) disable iff (rst)
      (in_vld && !mode64 && asz_ovr && seg_base == 64'd0)
      |=> (out_addr[63:16] == 48'd0));

   a_r7_no_seg_base: assert property (@(posedge clk) disable iff (rst)
      (in_vld && mode64 && !asz_ovr && !base_en && !idx_en && disp_val == 64'd0
       && seg_id != 3'd4 && seg_id != 3'd5)
      |=> (out_addr == 64'd0));
endmodule

bind lm_addr_gen lmag_chk u_chk (.*);

// File: tb/lm_addr_gen_tb.sv
module lm_addr_gen_tb;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_vld = 1'b0;
   logic        mode64 = 1'b1;
   logic        asz_ovr = 1'b0;
   logic [63:0] base_val = '0;
   logic        base_en = 1'b0;
   logic [63:0] idx_val = '0;
   logic        idx_en = 1'b0;
   logic [1:0]  scale = '0;
   logic [63:0] disp_val = '0;
   logic [1:0]  disp_sz = '0;
   logic [2:0]  seg_id = '0;
   logic [63:0] seg_base = '0;
   logic        out_vld;
   logic [63:0] out_addr;

   int total = 0;
   int bad = 0;
   bit ended = 0;

   always #10 clk = ~clk;

   lm_addr_gen u_dut (
      .clk(clk), .rst(rst), .in_vld(in_vld), .mode64(mode64), .asz_ovr(asz_ovr),
      .base_val(base_val), .base_en(base_en), .idx_val(idx_val), .idx_en(idx_en),
      .scale(scale), .disp_val(disp_val), .disp_sz(disp_sz), .seg_id(seg_id),
      .seg_base(seg_base), .out_vld(out_vld), .out_addr(out_addr)
   );

   task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic setup(input logic m, input logic o, input logic [63:0] b, input logic be,
                        input logic [63:0] x, input logic xe, input logic [1:0] s,
                        input logic [63:0] d, input logic [1:0] dz,
                        input logic [2:0] sid, input logic [63:0] sb);
      mode64 = m; asz_ovr = o; base_val = b; base_en = be; idx_val = x; idx_en = xe;
      scale = s; disp_val = d; disp_sz = dz; seg_id = sid; seg_base = sb;
   endtask

   // strobe one request at a negedge, check after the capturing edge
   task automatic fire_expect(input string tag, input logic [63:0] exp);
      in_vld = 1'b1;
      @(negedge clk);
      in_vld = 1'b0;
      chk({tag, " R9 valid"}, {63'd0, out_vld}, 64'd1);
      chk(tag, out_addr, exp);
   endtask

   task automatic t_reset_state();
      chk("R10 reset vld", {63'd0, out_vld}, 64'd0);
      chk("R10 reset addr", out_addr, 64'd0);
   endtask

   task automatic t_full64();
      setup(1, 0, 64'h1234_5678_9ABC_DEF0, 1, 64'h10, 1, 2'd3, 64'hF0, 2'd0, 3'd3, 64'hDEAD);
      fire_expect("R1 full sum", 64'h1234_5678_9ABC_DF60);
   endtask

   task automatic t_disp_sizes();
      setup(1, 0, 64'h1_0000, 1, 0, 0, 0, 64'h1234_5678_0000_8000, 2'd1, 3'd3, 0);
      fire_expect("R2 disp16 negative", 64'h8000);
      setup(1, 0, 0, 1, 0, 0, 0, 64'hAAAA_AAAA_FFFF_FFFF, 2'd2, 3'd3, 0);
      fire_expect("R2 disp32 negative", 64'hFFFF_FFFF_FFFF_FFFF);
      setup(1, 0, 64'h100, 1, 0, 0, 0, 64'hFF7F, 2'd0, 3'd3, 0);
      fire_expect("R2 disp8 positive", 64'h17F);
   endtask

   task automatic t_wide_disp();
      setup(1, 0, 64'h1, 1, 0, 0, 0, 64'h8000_0000_0000_0000, 2'd3, 3'd3, 0);
      fire_expect("R3 wide disp 64-bit", 64'h8000_0000_0000_0001);
      setup(0, 0, 64'h20, 1, 0, 0, 0, 64'h1234_5678_FFFF_FFF0, 2'd3, 3'd3, 0);
      fire_expect("R3 wide disp compat", 64'h10);
   endtask

   task automatic t_scale_enables();
      for (int s = 0; s < 4; s++) begin
         setup(1, 0, 64'h1000, 1, 64'h123, 1, 2'(s), 0, 2'd0, 3'd0, 0);
         fire_expect($sformatf("R4 scale %0d", s), 64'h1000 + (64'h123 << s));
      end
      setup(1, 0, 64'h1111, 0, 64'h3, 1, 2'd1, 0, 2'd0, 3'd0, 0);
      fire_expect("R4 base disabled", 64'h6);
      setup(1, 0, 64'h1111, 1, 64'h3, 0, 2'd1, 0, 2'd0, 3'd0, 0);
      fire_expect("R4 index disabled", 64'h1111);
   endtask

   task automatic t_ovr64();
      setup(1, 1, 64'h0000_0001_FFFF_FFF0, 1, 0, 0, 0, 64'h20, 2'd0, 3'd3, 64'h4444);
      fire_expect("R5 override truncate", 64'h10);
      setup(1, 1, 64'h0000_0001_FFFF_FFF0, 1, 0, 0, 0, 64'h20, 2'd0, 3'd4, 64'h7000_0000_0000_0000);
      fire_expect("R5 override then FS base", 64'h7000_0000_0000_0010);
   endtask

   task automatic t_compat();
      setup(0, 0, 64'h5555_0000_FFFF_FFF0, 1, 0, 0, 0, 64'h20, 2'd0, 3'd3, 64'h1000);
      fire_expect("R6 compat 32-bit", 64'h1010);
      setup(0, 1, 64'hFFFF, 1, 0, 0, 0, 64'h02, 2'd0, 3'd0, 64'h2000);
      fire_expect("R6 compat 16-bit", 64'h2001);
      setup(0, 0, 64'h100, 1, 0, 0, 0, 0, 2'd0, 3'd2, 64'h9999_9999_FFFF_FF00);
      fire_expect("R8 compat seg wrap", 64'h0);
      for (int k = 0; k < 8; k++) begin
         setup(0, 0, 64'h500, 1, 0, 0, 0, 0, 2'd0, 3'(k), 64'h1_0000_3000);
         fire_expect($sformatf("R8 compat seg %0d", k), 64'h3500);
      end
   endtask

   task automatic t_seg64();
      for (int k = 0; k < 8; k++) begin
         if (k == 4 || k == 5) continue;
         setup(1, 0, 64'h500, 1, 0, 0, 0, 0, 2'd0, 3'(k), 64'hAAAA_0000);
         fire_expect($sformatf("R7 seg %0d ignored", k), 64'h500);
      end
      setup(1, 0, 64'h500, 1, 0, 0, 0, 0, 2'd0, 3'd4, 64'h1_0000_0000);
      fire_expect("R7 FS base", 64'h1_0000_0500);
      setup(1, 0, 64'h500, 1, 0, 0, 0, 0, 2'd0, 3'd5, 64'hFFFF_FFFF_FFFF_FF00);
      fire_expect("R7 GS base wrap", 64'h400);
   endtask

   task automatic t_hold();
      setup(1, 0, 64'hABC, 1, 0, 0, 0, 0, 2'd0, 3'd3, 0);
      fire_expect("R9 before idle", 64'hABC);
      setup(1, 0, 64'hFFFF_0000, 1, 64'h7, 1, 2'd2, 64'h9, 2'd0, 3'd4, 64'h55);
      @(negedge clk);
      chk("R9 idle vld low", {63'd0, out_vld}, 64'd0);
      chk("R9 idle addr held", out_addr, 64'hABC);
   endtask

   task automatic t_sync_reset();
      setup(1, 0, 64'h777, 1, 0, 0, 0, 0, 2'd0, 3'd3, 0);
      fire_expect("R9 before reset", 64'h777);
      in_vld = 1'b1;
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      in_vld = 1'b0;
      chk("R10 sync reset vld", {63'd0, out_vld}, 64'd0);
      chk("R10 sync reset addr", out_addr, 64'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset_state();
      rst = 1'b0;
      @(negedge clk);
      t_full64();
      t_disp_sizes();
      t_wide_disp();
      t_scale_enables();
      t_ovr64();
      t_compat();
      t_seg64();
      t_hold();
      t_sync_reset();
      if (!ended) begin
         ended = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!ended) begin
         ended = 1;
         total++;
         bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule